// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one serial write transaction into a small page buffer and later copies them into a byte-wide storage array during a self-timed programming interval. A serial front end, which is not part of this block, raises a start strobe with the first byte address and a byte strobe for each received data byte. It raises a commit strobe when chip select is released, or an abort strobe if the transaction turns out to be invalid.

The buffer covers one page. The page part of the address is fixed when the transaction starts. The offset within the page advances by one after each byte and wraps inside the page, so a later byte can overwrite an earlier one. A per-offset valid mask records which offsets were loaded, and only those offsets are written to the array. While the programming interval runs, the busy output is high and every strobe is ignored. At the end of the interval a one-cycle done pulse tells the surrounding logic to clear its write-enable latch. The array is held inside the block and has a combinational read port.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy`, `arrWrEn` and `doneStb` are low and every array byte reads as 0x00.
- R2: The k-th data byte of a transaction (k counted from 0) goes to array address {startAddr[8:4], (startAddr[3:0]+k) mod 16}. Bits 8:4 of every write address equal bits 8:4 of the start address.
- R3: When more than 16 bytes are loaded, the byte loaded last at an offset is the one committed to that offset.
- R4: Only offsets loaded in the current transaction are written, with exactly one array write per loaded offset. All other array bytes keep their value.
- R5: The array changes only while `busy` is high, and only after a commit strobe.
- R6: A commit with at least one loaded byte makes `busy` high from the cycle after the commit edge for exactly WRITE_CYCLES cycles.
- R7: `doneStb` is high for exactly one cycle, and that cycle is the first one in which `busy` is low again.
- R8: An abort during a transaction discards the buffer. No busy interval follows, and a later commit without a new start has no effect.
- R9: A commit with zero loaded bytes ends the transaction, leaves `busy` low and gives no `doneStb`.
- R10: Start, byte and commit strobes received while `busy` is high are ignored. They change neither the array nor the length of the busy interval.
- R11: A start strobe clears the valid mask, so bytes from an earlier aborted transaction are never written.
- R12: Byte and commit strobes outside a transaction (no start seen since the last end) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Begin a write transaction at `startAddr` |
| startAddr | input | ADDR_W | First byte address; upper bits select the page |
| byteStb | input | 1 | One data byte is valid on `byteData` |
| byteData | input | DATA_W | Data byte |
| commitStb | input | 1 | Chip-select release: program the loaded bytes |
| abortIn | input | 1 | Discard the current transaction |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | DATA_W | Array byte at `rdAddr` (combinational) |
| busy | output | 1 | Programming interval in progress |
| arrWrEn | output | 1 | Array write strobe |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | DATA_W | Array write data |
| doneStb | output | 1 | One-cycle pulse at the end of programming; clears the write-enable latch |

## Verification
A wrong load pointer or page base shows up as a misplaced byte when the page is read back right after the busy interval. A broken offset wrap appears as soon as a transaction longer than 16 bytes is committed. A stale or never-cleared valid mask shows up in the number of array write strobes within the same busy interval, and as an overwritten byte at an offset that was not loaded. Timer faults change the measured busy length or move the done pulse, which the bench sees within WRITE_CYCLES+1 cycles of the commit.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pgState_e;

  // strobes from control to datapath, at most one of the first four per cycle
  typedef struct packed {
    logic captureStart;  // latch page/offset, clear valid mask
    logic loadByte;      // store byte at pointer, advance pointer
    logic discard;       // clear valid mask
    logic progStart;     // rewind the programming scan
    logic progScan;      // one scan step of the programming interval
  } pgStrobe_t;

endpackage

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic      byteStb,
  input  logic      commitStb,
  input  logic      abortIn,
  input  logic      maskAny,
  output pgStrobe_t ctl,
  output logic      busy,
  output logic      doneStb
);

  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  pgState_e   state, stNext;
  logic [TMR_W-1:0] timer;
  logic       timerLast;

  assign timerLast = (timer == TMR_W'(WRITE_CYCLES - 1));
  assign busy      = (state == ST_PROG);

  always_comb begin
    ctl    = '0;
    stNext = state;
    case (state)
      ST_IDLE: begin
        if (startStb) begin
          ctl.captureStart = 1'b1;
          stNext           = ST_FILL;
        end
      end
      ST_FILL: begin
        if (abortIn) begin
          ctl.discard = 1'b1;
          stNext      = ST_IDLE;
        end else if (commitStb) begin
          if (maskAny) begin
            ctl.progStart = 1'b1;
            stNext        = ST_PROG;
          end else begin
            ctl.discard = 1'b1;
            stNext      = ST_IDLE;
          end
        end else if (startStb) begin
          ctl.captureStart = 1'b1;
        end else if (byteStb) begin
          ctl.loadByte = 1'b1;
        end
      end
      ST_PROG: begin
        ctl.progScan = 1'b1;
        if (timerLast) begin
          ctl.discard = 1'b1;
          stNext      = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      doneStb <= 1'b0;
    end else begin
      state   <= stNext;
      doneStb <= busy && timerLast;
      if (ctl.progStart)      timer <= '0;
      else if (busy)          timer <= timer + 1'b1;
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  p_done_follows_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!busy && $past(busy)));

  p_empty_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && commitStb && !abortIn && !maskAny) |=> !busy);

  p_abort_no_prog_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && abortIn) |=> !busy);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !timerLast) |=> busy);

endmodule

// File: rtl/pgwr_data.sv
module pgwr_data
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              maskAny,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PAGE_W-1:0] pageBase;
  logic [OFF_W-1:0]  ptr;
  logic [OFF_W:0]    scanIdx;
  logic [OFF_W-1:0]  scanCur;
  logic              scanLive;
  logic [DATA_W-1:0] slotData [PAGE_BYTES];
  logic              slotValid [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] maskVec;
  logic [DATA_W-1:0] mem [DEPTH];

  // page base and load pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      ptr      <= '0;
    end else if (ctl.captureStart) begin
      pageBase <= startAddr[ADDR_W-1:OFF_W];
      ptr      <= startAddr[OFF_W-1:0];
    end else if (ctl.loadByte) begin
      ptr      <= ptr + 1'b1;
    end
  end

  // one buffer slot per page offset
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData[i]  <= '0;
        slotValid[i] <= 1'b0;
      end else if (ctl.captureStart || ctl.discard) begin
        slotValid[i] <= 1'b0;
      end else if (ctl.loadByte && ptr == OFF_W'(i)) begin
        slotData[i]  <= byteData;
        slotValid[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < PAGE_BYTES; i++) maskVec[i] = slotValid[i];
  end
  assign maskAny = |maskVec;

  // programming scan over page offsets
  assign scanCur  = scanIdx[OFF_W-1:0];
  assign scanLive = !scanIdx[OFF_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           scanIdx <= (OFF_W+1)'(PAGE_BYTES);
    else if (ctl.progStart)              scanIdx <= '0;
    else if (ctl.progScan && scanLive)   scanIdx <= scanIdx + 1'b1;
  end

  assign arrWrEn   = ctl.progScan && scanLive && maskVec[scanCur];
  assign arrWrAddr = {pageBase, scanCur};
  assign arrWrData = slotData[scanCur];

  // storage array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (arrWrEn) begin
      mem[arrWrAddr] <= arrWrData;
    end
  end

  assign rdData = mem[rdAddr];

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadByte && !ctl.captureStart) |=> (ptr == OFF_W'($past(ptr) + 1)));

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureStart |=> $stable(pageBase));

  p_mask_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureStart |=> (maskVec == '0));

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              commitStb,
  input  logic              abortIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic              doneStb
);

  if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_cycles
    $error("WRITE_CYCLES must cover one scan of the page");
  end

  pgStrobe_t ctl;
  logic      maskAny;

  pgwr_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .byteStb  (byteStb),
    .commitStb(commitStb),
    .abortIn  (abortIn),
    .maskAny  (maskAny),
    .ctl      (ctl),
    .busy     (busy),
    .doneStb  (doneStb)
  );

  pgwr_data #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(startAddr),
    .byteData (byteData),
    .rdAddr   (rdAddr),
    .maskAny  (maskAny),
    .arrWrEn  (arrWrEn),
    .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData),
    .rdData   (rdData)
  );

  p_wr_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

endmodule

// File: tb/pgwr_commit_bench.sv
module pgwr_commit_bench;

  localparam int AW = 9;
  localparam int DW = 8;
  localparam int PB = 16;
  localparam int WC = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0, byteStb = 1'b0, commitStb = 1'b0, abortIn = 1'b0;
  logic [AW-1:0] startAddr = '0, rdAddr = '0;
  logic [DW-1:0] byteData = '0;
  logic [DW-1:0] rdData, arrWrData;
  logic [AW-1:0] arrWrAddr;
  logic busy, arrWrEn, doneStb;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  pgwr_commit #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)
  ) u_pgwr_commit (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .byteStb(byteStb), .byteData(byteData), .commitStb(commitStb),
    .abortIn(abortIn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData),
    .doneStb(doneStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dataOf(input int page, input int k, input int len);
    return DW'(page * 7 + k * 13 + len * 3 + 1);
  endfunction

  // all tasks start and end just after a negative edge
  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doStart(input int addr);
    startAddr = AW'(addr); startStb = 1'b1; cycle(); startStb = 1'b0;
  endtask

  task automatic doByte(input logic [DW-1:0] d);
    byteData = d; byteStb = 1'b1; cycle(); byteStb = 1'b0;
  endtask

  task automatic doAbort();
    abortIn = 1'b1; cycle(); abortIn = 1'b0;
  endtask

  // commit, then measure busy length, array writes and done pulse
  task automatic commitMeasure(input int page, input int expWrites, input bit noise,
                               input string req);
    int blen = 0, wcount = 0, badPage = 0;
    bit doneOk;
    commitStb = 1'b1; cycle(); commitStb = 1'b0;
    while (busy && blen < 1000) begin
      blen++;
      if (arrWrEn) begin
        wcount++;
        if (int'(arrWrAddr >> 4) != page) badPage++;
      end
      if (noise && blen == 3) begin
        startAddr = '0; startStb = 1'b1; byteData = 8'hEE; commitStb = 1'b1;
      end
      if (noise && blen == 4) begin
        startStb = 1'b0; commitStb = 1'b0; byteStb = 1'b1;
      end
      if (noise && blen == 6) byteStb = 1'b0;
      cycle();
    end
    doneOk = doneStb;
    check(blen == WC, {req, " R6 busy length"}, blen, WC);
    check(doneOk, {req, " R7 done at busy fall"}, doneOk, 1);
    check(wcount == expWrites, {req, " R4 array write count"}, wcount, expWrites);
    check(badPage == 0, {req, " R2 write page fixed"}, badPage, 0);
    cycle();
    check(!doneStb, {req, " R7 done single cycle"}, doneStb, 0);
  endtask

  task automatic checkRange(input int lo, input int hi, input string req);
    int bad = 0, firstA = -1, firstAct = 0, firstExp = 0;
    for (int a = lo; a < hi; a++) begin
      rdAddr = AW'(a); #0.1;
      if (rdData !== model[a]) begin
        if (firstA < 0) begin firstA = a; firstAct = rdData; firstExp = model[a]; end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
    @(negedge clk);
  endtask

  task automatic quietWatch(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (busy || arrWrEn || doneStb) seen++;
      cycle();
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !arrWrEn && !doneStb, "R1 reset outputs", {busy, arrWrEn, doneStb}, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkRange(0, DEPTH, "R1 array cleared after reset");

    // sweep of start offset x length, length up to 20 covers the wrap (R2 R3 R4)
    for (int s = 0; s < PB; s++) begin
      for (int len = 1; len <= 20; len++) begin
        int page = (s * 20 + len) % (DEPTH / PB);
        doStart(page * PB + s);
        for (int k = 0; k < len; k++) begin
          logic [DW-1:0] d = dataOf(page, k, len);
          doByte(d);
          model[page * PB + (s + k) % PB] = d;
        end
        commitMeasure(page, (len < PB) ? len : PB, 1'b0, "R3 sweep");
        checkRange(page * PB, page * PB + PB, "R2 R3 R4 page contents");
      end
    end
    checkRange(0, DEPTH, "R4 whole array after sweep");

    // R8 abort discards, later commit without start ignored
    doStart(5 * PB + 2);
    doByte(8'hA1); doByte(8'hA2); doByte(8'hA3);
    doAbort();
    quietWatch(5, "R8 abort gives no busy");
    commitStb = 1'b1; cycle(); commitStb = 1'b0;
    quietWatch(WC + 2, "R8 commit after abort ignored");
    checkRange(5 * PB, 5 * PB + PB, "R8 page unchanged after abort");

    // R11 new start clears stale mask
    doStart(5 * PB + 2);
    doByte(8'hB1); doByte(8'hB2); doByte(8'hB3);
    doStart(5 * PB + 9);
    doByte(8'hC9);
    model[5 * PB + 9] = 8'hC9;
    commitMeasure(5, 1, 1'b0, "R11 restart");
    checkRange(5 * PB, 5 * PB + PB, "R11 stale bytes not written");

    // R9 empty commit
    doStart(7 * PB);
    commitStb = 1'b1; cycle(); commitStb = 1'b0;
    quietWatch(WC + 2, "R9 empty commit no busy no done");

    // R12 strobes outside a transaction
    doByte(8'h55);
    commitStb = 1'b1; cycle(); commitStb = 1'b0;
    quietWatch(WC + 2, "R12 idle strobes ignored");
    checkRange(0, DEPTH, "R12 array unchanged");

    // R10 strobes during busy ignored
    doStart(9 * PB + 14);
    doByte(8'h3C); doByte(8'h4D); doByte(8'h5E);
    model[9 * PB + 14] = 8'h3C; model[9 * PB + 15] = 8'h4D; model[9 * PB + 0] = 8'h5E;
    commitMeasure(9, 3, 1'b1, "R10 noisy busy");
    quietWatch(WC + 2, "R10 no second interval");
    checkRange(0, DEPTH, "R5 R10 array matches after noise");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule